// File: doc/BRIEF.md
# Change-of-Flow Trace Capture Unit

This block records the target addresses of change-of-flow events seen on a small CPU into a fixed-depth capture buffer. Software configures it through one 8-bit control byte holding a module enable, an arm flag, a loop-suppression mode, a breakpoint enable and a breakpoint-type select. While the unit is both enabled and armed, each valid event, made of an address and an access-type flag, is written into the next free buffer slot and the fill count advances.

In loop-suppression mode the unit keeps a single address register, here called comparator C. An event whose address equals that register is dropped. Any other event is stored and also replaces the register contents, so a tight loop that jumps to the same place again and again costs one buffer slot instead of filling the buffer. When the trace is in an event-only mode, suppression is switched off. The run ends when the buffer becomes full. The arm flag then drops by itself and, if breakpoints are enabled, a one-cycle force or tag breakpoint request goes to the CPU. A reset that ends a trace clears only part of the control byte, so the trace setup survives it. A secure input keeps the module disabled.

Top module: `trc_unit`

## Requirements
- R1: The control byte reads enable at bit 7, arm at bit 6, breakpoint type at bit 5 (1 = tag, 0 = force), breakpoint enable at bit 4 and loop-suppression mode at bit 0. Bits 3 to 1 read as zero. All bits are zero after `rst`, and a write shows on `ctl_rdata` from the following cycle.
- R2: In any cycle after one in which `secure` is high, bit 7 reads zero. A write that sets bit 7 while `secure` is high has no effect on it.
- R3: Events are captured only while enable and arm are both 1. Otherwise `fifo_count` does not change.
- R4: With loop-suppression off, or with `event_only` high, every qualifying event is stored at slot `fifo_count`, and `fifo_count` goes up by one on the next edge. Repeated addresses are stored again.
- R5: A stored entry is `{access_flag, address}`, with the access flag in the MSB. `rd_data` returns the entry at `rd_idx` one cycle after `rd_idx` is presented.
- R6: With loop-suppression on and `event_only` low, a qualifying event whose address equals the comparator C value held before the edge is not stored, and `fifo_count` stays the same.
- R7: With loop-suppression on, a stored event loads its address into comparator C (`cmp_c`) on the same edge. In normal mode `cmp_c` is left unchanged. `cmp_c` is zero after `rst`.
- R8: `event_only` high disables loop suppression, so a repeat of the comparator C address is stored.
- R9: The store that brings `fifo_count` to DEPTH also clears the arm bit on the same edge. A write that changes arm from 0 to 1 clears `fifo_count` to zero.
- R10: At the end of a run with breakpoint enable set, exactly one of `brk_tag` (type bit 1) or `brk_force` (type bit 0) pulses high for one cycle, in the cycle after the final store. With breakpoint enable clear, neither output rises.
- R11: A cycle with `trace_end_rst` high ignores `ctl_we`. If enable is 1 and `begin_trig` is 0, it clears only the arm and breakpoint-enable bits. Otherwise it clears every control bit. `fifo_count` and `cmp_c` are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| secure | input | 1 | Holds the module enable at zero |
| begin_trig | input | 1 | Trace is configured to trigger at the beginning |
| trace_end_rst | input | 1 | Reset that ends a trace run (partial control clear) |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Control byte readback |
| event_only | input | 1 | Trace is in an event-only mode |
| cof_valid | input | 1 | Change-of-flow event present |
| cof_addr | input | ADDR_W | Event target address |
| cof_acc | input | 1 | Event access-type flag |
| rd_idx | input | IDX_W | Buffer slot to read |
| rd_data | output | ADDR_W+1 | Registered buffer entry `{flag, address}` |
| fifo_count | output | CNT_W | Number of stored entries |
| cmp_c | output | ADDR_W | Comparator C address |
| brk_force | output | 1 | Force breakpoint request pulse |
| brk_tag | output | 1 | Tag breakpoint request pulse |

## Verification
The bound checker checks the following on every cycle:
- the secure lockout of the enable bit;
- that the count freezes whenever capture is not qualified or an event matches comparator C in loop mode;
- the comparator load on a loop-mode store;
- the one-hot, disarming nature of the breakpoint pulses;
- the partial clear on the trace-ending reset.

Only the bench scenarios show the rest: the exact buffer contents and their entry format, that repeats are stored in normal and event-only modes, which breakpoint type follows from each control setting, and the full control readback after each write and each reset flavour.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int CTL_W  = 8;
  localparam int EN_B   = 7;
  localparam int ARM_B  = 6;
  localparam int TAG_B  = 5;
  localparam int BRK_B  = 4;
  localparam int LOOP_B = 0;

  typedef struct packed {
    logic en;
    logic arm;
    logic tag;
    logic brk;
    logic loop;
  } ctl_t;
endpackage

// File: rtl/trc_ctl.sv
module trc_ctl
  import trc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             secure,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             end_rst,
  input  logic             begin_trig,
  input  logic             run_end,
  output ctl_t             ctl,
  output logic             arm_rise,
  output logic [CTL_W-1:0] rdata
);
  ctl_t nxt;

  // a trace-ending reset masks software writes
  assign arm_rise = wr_en & ~end_rst & wr_data[ARM_B] & ~ctl.arm;

  always_comb begin
    nxt = ctl;
    if (end_rst) begin
      if (ctl.en && !begin_trig) begin
        nxt.arm = 1'b0;
        nxt.brk = 1'b0;
      end else begin
        nxt = '0;
      end
    end else if (wr_en) begin
      nxt.en   = wr_data[EN_B];
      nxt.arm  = wr_data[ARM_B];
      nxt.tag  = wr_data[TAG_B];
      nxt.brk  = wr_data[BRK_B];
      nxt.loop = wr_data[LOOP_B];
    end
    if (run_end) nxt.arm = 1'b0;
    if (secure)  nxt.en  = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) ctl <= '0;
    else     ctl <= nxt;
  end

  always_comb begin
    rdata         = '0;
    rdata[EN_B]   = ctl.en;
    rdata[ARM_B]  = ctl.arm;
    rdata[TAG_B]  = ctl.tag;
    rdata[BRK_B]  = ctl.brk;
    rdata[LOOP_B] = ctl.loop;
  end
endmodule

// File: rtl/trc_capture.sv
module trc_capture
  import trc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 4,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  ctl_t              ctl,
  input  logic              event_only,
  input  logic              cof_valid,
  input  logic [ADDR_W-1:0] cof_addr,
  input  logic              cof_acc,
  input  logic              clr_cnt,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [ADDR_W:0]   wr_word,
  output logic [CNT_W-1:0]  count,
  output logic [ADDR_W-1:0] cmpc,
  output logic              run_end,
  output logic              brk_force,
  output logic              brk_tag
);
  logic qual;
  logic loop_on;
  logic hit;

  assign qual    = cof_valid & ctl.en & ctl.arm & (count < CNT_W'(DEPTH));
  assign loop_on = ctl.loop & ~event_only;
  assign hit     = loop_on & (cof_addr == cmpc);
  assign wr_en   = qual & ~hit;
  assign wr_idx  = count[IDX_W-1:0];
  assign wr_word = {cof_acc, cof_addr};
  assign run_end = wr_en & (count == CNT_W'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      count     <= '0;
      cmpc      <= '0;
      brk_force <= 1'b0;
      brk_tag   <= 1'b0;
    end else begin
      if (clr_cnt)    count <= '0;
      else if (wr_en) count <= count + 1'b1;
      if (wr_en && loop_on) cmpc <= cof_addr;
      brk_force <= run_end & ctl.brk & ~ctl.tag;
      brk_tag   <= run_end & ctl.brk & ctl.tag;
    end
  end
endmodule

// File: rtl/trc_buf.sv
module trc_buf #(
  parameter int W     = 17,
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [W-1:0]     wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [W-1:0]     rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/trc_unit.sv
module trc_unit
  import trc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int ENT_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              secure,
  input  logic              begin_trig,
  input  logic              trace_end_rst,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic [CTL_W-1:0]  ctl_rdata,
  input  logic              event_only,
  input  logic              cof_valid,
  input  logic [ADDR_W-1:0] cof_addr,
  input  logic              cof_acc,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ENT_W-1:0]  rd_data,
  output logic [CNT_W-1:0]  fifo_count,
  output logic [ADDR_W-1:0] cmp_c,
  output logic              brk_force,
  output logic              brk_tag
);
  ctl_t             ctl;
  logic             arm_rise;
  logic             run_end;
  logic             st_en;
  logic [IDX_W-1:0] st_idx;
  logic [ENT_W-1:0] st_word;

  trc_ctl u_ctl (
    .clk        (clk),
    .rst        (rst),
    .secure     (secure),
    .wr_en      (ctl_we),
    .wr_data    (ctl_wdata),
    .end_rst    (trace_end_rst),
    .begin_trig (begin_trig),
    .run_end    (run_end),
    .ctl        (ctl),
    .arm_rise   (arm_rise),
    .rdata      (ctl_rdata)
  );

  trc_capture #(
    .ADDR_W (ADDR_W),
    .DEPTH  (DEPTH),
    .CNT_W  (CNT_W),
    .IDX_W  (IDX_W)
  ) u_cap (
    .clk        (clk),
    .rst        (rst),
    .ctl        (ctl),
    .event_only (event_only),
    .cof_valid  (cof_valid),
    .cof_addr   (cof_addr),
    .cof_acc    (cof_acc),
    .clr_cnt    (arm_rise),
    .wr_en      (st_en),
    .wr_idx     (st_idx),
    .wr_word    (st_word),
    .count      (fifo_count),
    .cmpc       (cmp_c),
    .run_end    (run_end),
    .brk_force  (brk_force),
    .brk_tag    (brk_tag)
  );

  trc_buf #(
    .W     (ENT_W),
    .DEPTH (DEPTH),
    .IDX_W (IDX_W)
  ) u_buf (
    .clk   (clk),
    .we    (st_en),
    .waddr (st_idx),
    .wdata (st_word),
    .raddr (rd_idx),
    .rdata (rd_data)
  );
endmodule

// File: rtl/trc_unit_chk.sv
module trc_unit_chk #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              secure,
  input logic              begin_trig,
  input logic              trace_end_rst,
  input logic              ctl_we,
  input logic [7:0]        ctl_wdata,
  input logic [7:0]        ctl_rdata,
  input logic              event_only,
  input logic              cof_valid,
  input logic [ADDR_W-1:0] cof_addr,
  input logic [CNT_W-1:0]  fifo_count,
  input logic [ADDR_W-1:0] cmp_c,
  input logic              brk_force,
  input logic              brk_tag
);
  logic en_q, arm_q, loop_q, no_rise;
  assign en_q    = ctl_rdata[7];
  assign arm_q   = ctl_rdata[6];
  assign loop_q  = ctl_rdata[0];
  assign no_rise = !(ctl_we && !trace_end_rst && ctl_wdata[6] && !arm_q);

  // R2
  secure_lock_chk: assert property (@(posedge clk) disable iff (rst)
    secure |=> !en_q);

  // R3
  idle_count_chk: assert property (@(posedge clk) disable iff (rst)
    (!(en_q && arm_q) && no_rise) |=> $stable(fifo_count));

  // R6
  loop_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (cof_valid && en_q && arm_q && loop_q && !event_only && cof_addr == cmp_c)
      |=> $stable(fifo_count));

  // R7
  cmp_load_chk: assert property (@(posedge clk) disable iff (rst)
    (cof_valid && en_q && arm_q && loop_q && !event_only && cof_addr != cmp_c)
      |=> cmp_c == $past(cof_addr));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_count <= CNT_W'(DEPTH));

  // R10
  brk_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({brk_force, brk_tag}));

  // R10
  brk_disarm_chk: assert property (@(posedge clk) disable iff (rst)
    (brk_force || brk_tag) |-> (!arm_q && fifo_count == CNT_W'(DEPTH)));

  // R11
  end_rst_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (trace_end_rst && en_q && !begin_trig && !secure)
      |=> (!ctl_rdata[6] && !ctl_rdata[4] && ctl_rdata[7]
           && ctl_rdata[5] == $past(ctl_rdata[5])
           && ctl_rdata[0] == $past(ctl_rdata[0])));
endmodule

bind trc_unit trc_unit_chk #(
  .ADDR_W (ADDR_W),
  .DEPTH  (DEPTH),
  .CNT_W  (CNT_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .secure        (secure),
  .begin_trig    (begin_trig),
  .trace_end_rst (trace_end_rst),
  .ctl_we        (ctl_we),
  .ctl_wdata     (ctl_wdata),
  .ctl_rdata     (ctl_rdata),
  .event_only    (event_only),
  .cof_valid     (cof_valid),
  .cof_addr      (cof_addr),
  .fifo_count    (fifo_count),
  .cmp_c         (cmp_c),
  .brk_force     (brk_force),
  .brk_tag       (brk_tag)
);

// File: tb/sim_trc_unit.sv
`timescale 1ns/1ps
module sim_trc_unit;
  localparam int AW    = 16;
  localparam int DEPTH = 8;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int IW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          secure = 1'b0, begin_trig = 1'b0, trace_end_rst = 1'b0;
  logic          ctl_we = 1'b0;
  logic [7:0]    ctl_wdata = '0;
  logic [7:0]    ctl_rdata;
  logic          event_only = 1'b0, cof_valid = 1'b0, cof_acc = 1'b0;
  logic [AW-1:0] cof_addr = '0;
  logic [IW-1:0] rd_idx = '0;
  logic [AW:0]   rd_data;
  logic [CW-1:0] fifo_count;
  logic [AW-1:0] cmp_c;
  logic          brk_force, brk_tag;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  trc_unit #(.ADDR_W(AW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .secure(secure), .begin_trig(begin_trig),
    .trace_end_rst(trace_end_rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .event_only(event_only), .cof_valid(cof_valid),
    .cof_addr(cof_addr), .cof_acc(cof_acc), .rd_idx(rd_idx), .rd_data(rd_data),
    .fifo_count(fifo_count), .cmp_c(cmp_c), .brk_force(brk_force), .brk_tag(brk_tag)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit m_en, m_arm, m_tag, m_brk, m_loop, m_bf, m_bt;
  int m_cnt;
  logic [AW-1:0] m_cmpc;
  logic [AW:0] mq[$];
  bit q, lo, hit, st, ar, fin;

  function automatic int m_ctl();
    return {m_en, m_arm, m_tag, m_brk, 3'b000, m_loop};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      {m_en, m_arm, m_tag, m_brk, m_loop, m_bf, m_bt} = '0;
      m_cnt = 0; m_cmpc = '0; mq.delete();
    end else begin
      q   = cof_valid && m_en && m_arm;
      lo  = m_loop && !event_only;
      hit = lo && (cof_addr == m_cmpc);
      st  = q && !hit;
      ar  = ctl_we && !trace_end_rst && ctl_wdata[6] && !m_arm;
      fin = st && (m_cnt == DEPTH - 1);
      m_bf = fin && m_brk && !m_tag;
      m_bt = fin && m_brk && m_tag;
      if (st) begin
        mq.push_back({cof_acc, cof_addr});
        m_cnt++;
        if (lo) m_cmpc = cof_addr;
      end
      if (ar) begin m_cnt = 0; mq.delete(); end
      if (trace_end_rst) begin
        if (m_en && !begin_trig) begin m_arm = 0; m_brk = 0; end
        else {m_en, m_arm, m_tag, m_brk, m_loop} = '0;
      end else if (ctl_we) begin
        {m_en, m_arm, m_tag, m_brk} = ctl_wdata[7:4];
        m_loop = ctl_wdata[0];
      end
      if (fin) m_arm = 0;
      if (secure) m_en = 0;
    end
  end

  always @(posedge clk) begin
    #2;
    chk("R1 model ctl_rdata", ctl_rdata, m_ctl());
    chk("R4/R6/R9 model fifo_count", fifo_count, m_cnt);
    chk("R7 model cmp_c", cmp_c, m_cmpc);
    chk("R10 model brk_force", brk_force, m_bf);
    chk("R10 model brk_tag", brk_tag, m_bt);
  end

  task automatic wr_ctl(logic [7:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic ev(logic [AW-1:0] a, logic f);
    @(negedge clk); cof_valid = 1'b1; cof_addr = a; cof_acc = f;
    @(negedge clk); cof_valid = 1'b0;
  endtask

  task automatic rd_chk(int idx, int exp, string req);
    @(negedge clk); rd_idx = IW'(idx);
    @(negedge clk); chk(req, rd_data, exp);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset ctl", ctl_rdata, 8'h00);
    chk("R7 reset cmp_c", cmp_c, 0);

    // R2: write of enable blocked while secure
    secure = 1'b1;
    wr_ctl(8'h80);
    chk("R2 enable blocked", ctl_rdata, 8'h00);
    secure = 1'b0;

    // R1: layout, bits 3..1 read zero
    wr_ctl(8'hFF);
    chk("R1 layout", ctl_rdata, 8'hF1);
    wr_ctl(8'hC0);

    // R4 normal mode stores repeats; R5 format
    ev(16'h1234, 1'b0); ev(16'h1234, 1'b1); ev(16'h5678, 1'b0);
    chk("R4 normal count", fifo_count, 3);
    chk("R7 normal mode cmp_c untouched", cmp_c, 0);
    rd_chk(0, 17'h01234, "R5 entry 0");
    rd_chk(1, 17'h11234, "R5 entry 1 flag in msb");

    // R3: not armed / not enabled
    wr_ctl(8'h80);
    ev(16'h2222, 1'b0);
    chk("R3 disarmed ignored", fifo_count, 3);
    wr_ctl(8'h40);
    chk("R9 arm rise clears count", fifo_count, 0);
    ev(16'h2222, 1'b0);
    chk("R3 disabled ignored", fifo_count, 0);

    // R6/R7 loop suppression
    wr_ctl(8'hC1);
    ev(16'h0100, 1'b0); ev(16'h0100, 1'b0); ev(16'h0100, 1'b0);
    chk("R6 repeats dropped", fifo_count, 1);
    ev(16'h0200, 1'b1); ev(16'h0200, 1'b1); ev(16'h0100, 1'b0);
    chk("R6 loop count", fifo_count, 3);
    chk("R7 cmp_c loaded", cmp_c, 16'h0100);
    rd_chk(1, 17'h10200, "R5 loop entry 1");

    // R8 event-only disables suppression
    event_only = 1'b1;
    ev(16'h0200, 1'b0); ev(16'h0200, 1'b0);
    chk("R8 event-only stores repeats", fifo_count, 5);
    chk("R7 event-only leaves cmp_c", cmp_c, 16'h0100);
    event_only = 1'b0;

    // R9/R10 force request at run end
    wr_ctl(8'hD1);
    ev(16'h0300, 1'b0); ev(16'h0301, 1'b0); ev(16'h0302, 1'b0);
    chk("R10 force pulse", brk_force, 1);
    chk("R10 no tag pulse", brk_tag, 0);
    chk("R9 arm cleared at full", ctl_rdata, 8'h91);
    chk("R9 count full", fifo_count, DEPTH);
    @(negedge clk);
    chk("R10 force pulse one cycle", brk_force, 0);

    // R10 tag request
    wr_ctl(8'hF0);
    for (int i = 0; i < DEPTH; i++) ev(AW'(16'h0400 + i), 1'b0);
    chk("R10 tag pulse", brk_tag, 1);
    chk("R10 tag no force", brk_force, 0);
    chk("R9 tag run disarmed", ctl_rdata, 8'hB0);

    // R10 no request with break enable clear
    wr_ctl(8'hC0);
    for (int i = 0; i < DEPTH; i++) ev(AW'(16'h0500 + i), 1'b1);
    chk("R10 no force when disabled", brk_force, 0);
    chk("R10 no tag when disabled", brk_tag, 0);
    chk("R9 disarmed at full", ctl_rdata, 8'h80);

    // R11 trace-ending reset
    wr_ctl(8'hF1);
    ev(16'h0600, 1'b0);
    @(negedge clk); trace_end_rst = 1'b1;
    @(negedge clk); trace_end_rst = 1'b0;
    chk("R11 partial clear", ctl_rdata, 8'hA1);
    chk("R11 count kept", fifo_count, 1);
    wr_ctl(8'hF1);
    @(negedge clk); begin_trig = 1'b1; trace_end_rst = 1'b1;
    @(negedge clk); trace_end_rst = 1'b0; begin_trig = 1'b0;
    chk("R11 full clear with begin trigger", ctl_rdata, 8'h00);

    // R2 secure drops an already set enable
    wr_ctl(8'h80);
    @(negedge clk); secure = 1'b1;
    @(negedge clk); secure = 1'b0;
    chk("R2 secure clears enable", ctl_rdata, 8'h00);

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule